// File: doc/BRIEF.md
# UART Internal Loop-Back Path

This block sits on one channel of a 16550-style UART, between the UART core and the external pins. The core supplies a serial transmit stream and four modem control outputs. These are request-to-send, data-terminal-ready and two general outputs. The core expects a serial receive stream and four modem status inputs back. These are clear-to-send, data-set-ready, ring indicator and carrier detect. In normal operation the block passes the transmit stream and the control outputs to the pins. It brings the external receive and status pins back to the core through reset-safe synchronizers.

When the loop-back bit of the modem control register is set, the block closes both paths inside the chip. The transmit stream goes straight back into the receive input, so a byte written for transmission comes back as a received byte. Each control output is fed into its paired status input. The transmit pin rests at the idle level and the control pins go inactive. The external receive and status pins are ignored. The block also derives one-cycle change strobes from the status inputs as the core sees them. Because these strobes are taken after the multiplexer, modem-status interrupts keep working in loop-back.

All results come from registers. A change of mode takes effect at the next clock edge, and the internal receive line never carries a partial or combinational value.

Top module: `uart_loopback_path`

## Requirements
- R1: The mode input `mcr_loop` is sampled at each rising clock edge. The outputs after that edge follow the mode sampled at that edge, so a switch in either direction takes effect one clock after the input changes.
- R2: In loop-back, `core_rxd` equals the `core_txd` value sampled at the previous edge, which is a one-cycle delay.
- R3: In loop-back, `pin_txd` is 1, the idle level.
- R4: In loop-back, `pin_mout` is 4'b1111. The control pins are active-low, so this drives all four inactive.
- R5: In loop-back, `core_min` equals `core_mout` from one edge earlier with bit positions kept. The `core_mout` bits are bit0 request-to-send, bit1 terminal-ready, bit2 general output 1 and bit3 general output 2. Each of these feeds `core_min` bit0 clear-to-send, bit1 set-ready, bit2 ring indicator and bit3 carrier detect, in that order.
- R6: In loop-back, `pin_rxd` and `pin_min` have no effect on `core_rxd` or `core_min`.
- R7: In normal mode, `pin_txd` equals `core_txd` one edge earlier, and `pin_mout` equals the bitwise inverse of `core_mout` one edge earlier.
- R8: In normal mode, `core_rxd` equals `pin_rxd` and `core_min` equals the bitwise inverse of `pin_min`. Both are taken as sampled SYNC_STAGES+1 edges earlier (3 by default).
- R9: Bit i of `core_mdelta` is 1 for exactly one cycle. That cycle is the one after `core_min[i]` changes, whichever path caused the change.
- R10: While `rst_n` is low, the outputs are `core_rxd`=1, `pin_txd`=1, `pin_mout`=4'b1111, `core_min`=0 and `core_mdelta`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcr_loop | input | 1 | Loop-back enable bit from the modem control register |
| core_txd | input | 1 | Serial transmit stream from the core |
| core_rxd | output | 1 | Serial receive stream to the core |
| pin_txd | output | 1 | External transmit pin |
| pin_rxd | input | 1 | External receive pin (asynchronous) |
| core_mout | input | 4 | Control outputs from the core, active-high |
| pin_mout | output | 4 | External control pins, active-low |
| pin_min | input | 4 | External status pins, active-low (asynchronous) |
| core_min | output | 4 | Status inputs to the core, active-high |
| core_mdelta | output | 4 | One-cycle change strobes of core_min |

## Verification
Each result arrives after a fixed number of rising edges. The transmit pin, the control pins and both loop-back paths arrive one edge after their inputs. The normal receive and status paths arrive SYNC_STAGES+1 edges after the pins. The change strobes arrive one edge after `core_min` moves. The bench drives inputs on falling edges and keeps a three-deep history of what each rising edge saw. At each falling edge it compares the outputs with values computed from the right history entry, with the mode taken from the newest entry. It also carries its own copy of the last two expected `core_min` values to predict the strobes.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int MODEM_W = 4;
  typedef logic [MODEM_W-1:0] modem_t;

  localparam int IDX_RTS_CTS = 0;
  localparam int IDX_DTR_DSR = 1;
  localparam int IDX_OP1_RI  = 2;
  localparam int IDX_OP2_CD  = 3;

  localparam modem_t PIN_INACTIVE  = '1;
  localparam modem_t CORE_INACTIVE = '0;
  localparam logic   LINE_IDLE     = 1'b1;

  // Route each control output onto its paired status input.
  function automatic modem_t loop_map(input modem_t mout);
    modem_t m;
    m[IDX_RTS_CTS] = mout[IDX_RTS_CTS];
    m[IDX_DTR_DSR] = mout[IDX_DTR_DSR];
    m[IDX_OP1_RI]  = mout[IDX_OP1_RI];
    m[IDX_OP2_CD]  = mout[IDX_OP2_CD];
    return m;
  endfunction

  // Pins are active-low, core side is active-high.
  function automatic modem_t flip_level(input modem_t v);
    return ~v;
  endfunction

  function automatic modem_t change_mask(input modem_t now_v, input modem_t old_v);
    return now_v ^ old_v;
  endfunction
endpackage

// File: rtl/uart_lb_sync.sv
module uart_lb_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [WIDTH-1:0] st [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= RESET_VAL;
            else        st[i] <= din;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= RESET_VAL;
            else        st[i] <= st[i-1];
          end
        end
      end
      assign dout = st[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/uart_lb_steer.sv
module uart_lb_steer
  import uart_lb_pkg::*;
(
  input  logic   loop_en,
  input  logic   core_txd,
  input  logic   rxd_s,
  input  modem_t core_mout,
  input  modem_t min_s,
  output logic   nxt_core_rxd,
  output logic   nxt_pin_txd,
  output modem_t nxt_pin_mout,
  output modem_t nxt_core_min
);
  always_comb begin
    if (loop_en) begin
      nxt_core_rxd = core_txd;
      nxt_pin_txd  = LINE_IDLE;
      nxt_pin_mout = PIN_INACTIVE;
      nxt_core_min = loop_map(core_mout);
    end else begin
      nxt_core_rxd = rxd_s;
      nxt_pin_txd  = core_txd;
      nxt_pin_mout = flip_level(core_mout);
      nxt_core_min = flip_level(min_s);
    end
  end
endmodule

// File: rtl/uart_lb_delta.sv
module uart_lb_delta
  import uart_lb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  modem_t min_now,
  output modem_t delta
);
  modem_t prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= CORE_INACTIVE;
      delta  <= '0;
    end else begin
      prev_q <= min_now;
      delta  <= change_mask(min_now, prev_q);
    end
  end
endmodule

// File: rtl/uart_loopback_path.sv
module uart_loopback_path
  import uart_lb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mcr_loop,
  input  logic       core_txd,
  output logic       core_rxd,
  output logic       pin_txd,
  input  logic       pin_rxd,
  input  logic [3:0] core_mout,
  output logic [3:0] pin_mout,
  input  logic [3:0] pin_min,
  output logic [3:0] core_min,
  output logic [3:0] core_mdelta
);
  localparam int RX_W = 1 + MODEM_W;

  logic   rxd_s;
  modem_t min_s;
  logic   nxt_core_rxd, nxt_pin_txd;
  modem_t nxt_pin_mout, nxt_core_min;
  logic [RX_W-1:0] raw_in, sync_out;

  assign raw_in = {pin_rxd, pin_min};

  uart_lb_sync #(
    .WIDTH(RX_W), .STAGES(SYNC_STAGES), .RESET_VAL({LINE_IDLE, PIN_INACTIVE})
  ) i_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(sync_out)
  );

  assign rxd_s = sync_out[RX_W-1];
  assign min_s = sync_out[MODEM_W-1:0];

  uart_lb_steer i_steer (
    .loop_en(mcr_loop), .core_txd(core_txd), .rxd_s(rxd_s),
    .core_mout(core_mout), .min_s(min_s),
    .nxt_core_rxd(nxt_core_rxd), .nxt_pin_txd(nxt_pin_txd),
    .nxt_pin_mout(nxt_pin_mout), .nxt_core_min(nxt_core_min)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_rxd <= LINE_IDLE;
      pin_txd  <= LINE_IDLE;
      pin_mout <= PIN_INACTIVE;
      core_min <= CORE_INACTIVE;
    end else begin
      core_rxd <= nxt_core_rxd;
      pin_txd  <= nxt_pin_txd;
      pin_mout <= nxt_pin_mout;
      core_min <= nxt_core_min;
    end
  end

  uart_lb_delta i_delta (
    .clk(clk), .rst_n(rst_n), .min_now(core_min), .delta(core_mdelta)
  );
endmodule

// File: rtl/uart_loopback_path_chk.sv
module uart_loopback_path_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mcr_loop,
  input logic       core_txd,
  input logic [3:0] core_mout,
  input logic       core_rxd,
  input logic       pin_txd,
  input logic [3:0] pin_mout,
  input logic [3:0] core_min,
  input logic [3:0] core_mdelta,
  input logic       rxd_s,
  input logic [3:0] min_s
);
  logic seen1, seen2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else begin
      seen1 <= 1'b1;
      seen2 <= seen1;
    end
  end

  assert_loop_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen1 && $past(mcr_loop)) |-> (core_rxd == $past(core_txd)));

  assert_tx_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen1 && $past(mcr_loop)) |-> pin_txd);

  assert_mout_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen1 && $past(mcr_loop)) |-> (pin_mout == 4'hF));

  assert_modem_loop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen1 && $past(mcr_loop)) |-> (core_min == $past(core_mout)));

  assert_pass_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen1 && !$past(mcr_loop)) |->
      (pin_txd == $past(core_txd) && pin_mout == ~$past(core_mout)));

  assert_pass_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen1 && !$past(mcr_loop)) |->
      (core_rxd == $past(rxd_s) && core_min == ~$past(min_s)));

  assert_delta_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen2 |-> (core_mdelta == ($past(core_min) ^ $past(core_min, 2))));
endmodule

bind uart_loopback_path uart_loopback_path_chk i_chk (.*);

// File: tb/test_uart_loopback_path.sv
module test_uart_loopback_path;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mcr_loop = 1'b0, core_txd = 1'b1, pin_rxd = 1'b1;
  logic [3:0] core_mout = 4'h0, pin_min = 4'hF;
  logic core_rxd, pin_txd;
  logic [3:0] pin_mout, core_min, core_mdelta;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct packed {
    logic lp; logic txd; logic rxd; logic [3:0] mout; logic [3:0] min;
  } stim_t;
  localparam stim_t IDLE_STIM = '{lp:1'b0, txd:1'b1, rxd:1'b1, mout:4'h0, min:4'hF};

  stim_t h0 = IDLE_STIM, h1 = IDLE_STIM, h2 = IDLE_STIM;
  logic [3:0] em1 = 4'h0, em2 = 4'h0;

  always #2.5 clk = ~clk;

  uart_loopback_path #(.SYNC_STAGES(SYNC)) i_uart_loopback_path (
    .clk(clk), .rst_n(rst_n), .mcr_loop(mcr_loop), .core_txd(core_txd),
    .core_rxd(core_rxd), .pin_txd(pin_txd), .pin_rxd(pin_rxd),
    .core_mout(core_mout), .pin_mout(pin_mout), .pin_min(pin_min),
    .core_min(core_min), .core_mdelta(core_mdelta)
  );

  // Expected status seen by the core: loop pairs rts->cts, dtr->dsr, op1->ri, op2->cd.
  function automatic logic [3:0] exp_status(stim_t now, stim_t old);
    logic [3:0] r;
    if (now.lp) begin
      r[0] = now.mout[0]; r[1] = now.mout[1]; r[2] = now.mout[2]; r[3] = now.mout[3];
    end else begin
      for (int i = 0; i < 4; i++) r[i] = !old.min[i];
    end
    return r;
  endfunction

  function automatic logic exp_rx(stim_t now, stim_t old);
    return now.lp ? now.txd : old.rxd;
  endfunction

  function automatic logic [3:0] exp_pins(stim_t now);
    return now.lp ? 4'hF : ~now.mout;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_edge();
    logic [3:0] ms;
    ms = exp_status(h0, h2);
    if (h0.lp) begin
      chk("R2/R6 core_rxd loop", {3'b0, core_rxd}, {3'b0, exp_rx(h0, h2)});
      chk("R1/R3 pin_txd idle", {3'b0, pin_txd}, 4'h1);
      chk("R4 pin_mout inactive", pin_mout, 4'hF);
      chk("R5/R6 core_min loop", core_min, ms);
    end else begin
      chk("R1/R8 core_rxd pin", {3'b0, core_rxd}, {3'b0, exp_rx(h0, h2)});
      chk("R7 pin_txd pass", {3'b0, pin_txd}, {3'b0, h0.txd});
      chk("R7 pin_mout pass", pin_mout, exp_pins(h0));
      chk("R8 core_min pin", core_min, ms);
    end
    chk("R9 core_mdelta", core_mdelta, em1 ^ em2);
    em2 = em1;
    em1 = ms;
  endtask

  task automatic step(input stim_t s);
    @(negedge clk);
    check_edge();
    h2 = h1; h1 = h0; h0 = s;
    mcr_loop = s.lp; core_txd = s.txd; pin_rxd = s.rxd;
    core_mout = s.mout; pin_min = s.min;
  endtask

  function automatic stim_t mk(logic lp, logic txd, logic rxd, logic [3:0] mo, logic [3:0] mi);
    stim_t s;
    s.lp = lp; s.txd = txd; s.rxd = rxd; s.mout = mo; s.min = mi;
    return s;
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    stim_t s;
    logic lp;
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    // R10: values held in reset
    chk("R10 core_rxd reset", {3'b0, core_rxd}, 4'h1);
    chk("R10 pin_txd reset", {3'b0, pin_txd}, 4'h1);
    chk("R10 pin_mout reset", pin_mout, 4'hF);
    chk("R10 core_min reset", core_min, 4'h0);
    chk("R10 core_mdelta reset", core_mdelta, 4'h0);
    rst_n = 1'b1;
    // Directed normal mode: walking control outputs and status pins
    for (int i = 0; i < 8; i++)
      step(mk(1'b0, i[0], ~i[0], 4'(1 << (i % 4)), ~4'(1 << ((i + 1) % 4))));
    // Directed loop-back, pins forced opposite to looped values (R6)
    for (int i = 0; i < 12; i++)
      step(mk(1'b1, i[1], ~i[1], 4'(1 << (i % 4)), 4'(1 << (i % 4))));
    // Switch out and back in while all inputs hold still (R1)
    step(mk(1'b0, 1'b0, 1'b1, 4'hA, 4'h3));
    step(mk(1'b0, 1'b0, 1'b1, 4'hA, 4'h3));
    step(mk(1'b1, 1'b0, 1'b1, 4'hA, 4'h3));
    step(mk(1'b0, 1'b0, 1'b1, 4'hA, 4'h3));
    for (int i = 0; i < 4; i++) step(mk(1'b1, 1'b0, 1'b1, 4'hA, 4'h3));
    // Random mix
    lp = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(15) == 0) lp = ~lp;
      s = mk(lp, 1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom));
      step(s);
    end
    step(IDLE_STIM);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule